// File: doc/BRIEF.md
# Condition Code Generator

This block turns the outcome of an integer, logical, shift or vector-compare operation into a 2-bit condition code. A 5-bit selector names the operation class. Up to three operands qualify it: a source, a destination (usually the result) and an extra result word. Classes include signed and unsigned ordering, masked bit tests, add and subtract with overflow or carry, absolute value and complement, multiply range checks, arithmetic left shift, leading-one search, block counts and vector match masks. All classes share one code space of 0 to 3.

The decode logic is combinational and its output is registered. The data path is a one-way stream. When `in_valid` is high, the block captures the selector and operands on that edge. It presents the code with `out_valid` high one cycle later. The block is always ready and applies no back-pressure, so a producer may present a new operation on every cycle. When no operation is presented, `cc_o` and `err_o` keep their last values. A selector with no defined meaning raises `err_o`, and `cc_o` keeps its previous value.

Top module: `cond_code_gen`

## Requirements
- R1: Reset clears `cc_o`, `err_o` and `out_valid`. An operation accepted with `in_valid` appears on `cc_o`/`err_o` with `out_valid`=1 in the next cycle. In a cycle without `in_valid`, `out_valid` is 0 and `cc_o`/`err_o` hold.
- R2: Selectors 0..3 give a code equal to the selector value.
- R3: Ordering selectors give code 0 for equal operands, 1 when the first operand is less than the second, and 2 when it is greater.
  - 6 compares `src_i` with `dst_i` as signed low 32 bits.
  - 7 compares `src_i` with `dst_i` as signed 64 bits.
  - 8 is the unsigned 32-bit compare and 9 the unsigned 64-bit compare.
  - 4 compares signed `dst_i[31:0]` against zero, and 5 compares signed 64-bit `dst_i` against zero.
- R4: Masked test, with value `src_i` and mask `dst_i`.
  - Let t = value AND mask. The code is 0 when t=0 and 3 when t equals the mask.
  - Selector 10 works on the low 32 bits and gives 1 for any other t.
  - Selector 11 works on 64 bits. For any other t it gives 2 if the value bit at the mask's highest set position is 1, and 1 otherwise.
- R5: Selector 12 is a masked insert result, with mask `src_i` and value `dst_i`. The code is 0 when value AND mask is 0. Otherwise it is 1 if the value bit at the mask's highest set position is 1, and 2 if that bit is 0.
- R6: Signed add and subtract, with operands `src_i` and `dst_i` and result `xres_i`.
  - Selectors: 13 is add and 15 is subtract at 32 bits; 14 is add and 16 is subtract at 64 bits.
  - Add overflow: both operands are positive and the result is negative, or both are negative and the result is not negative.
  - Subtract overflow: the first operand is not negative, the second is negative and the result is negative; or the first is negative, the second is positive and the result is positive.
  - The code is 3 on overflow. Otherwise it is 1 for a negative result, 0 for zero and 2 for a positive result.
- R7: Logical add and subtract use the result `dst_i` and the flag `src_i[0]`.
  - Selector 17 (add, flag is the carry) gives 2×carry + (result≠0).
  - Selector 18 (subtract, flag is the borrow flag) gives 2×(NOT flag) + (result≠0).
- R8: Single-operand classes take their operand from `dst_i`; the 32-bit forms read the low half.
  - Absolute value (19 at 32 bits, 20 at 64 bits) gives 3 for the most negative value of its width, 0 for zero and 2 otherwise.
  - Negative absolute value (21 at 32 bits, 22 at 64 bits) gives 0 for zero and 1 otherwise.
  - Complement (23 at 32 bits, 24 at 64 bits) gives 3 for the most negative value, and otherwise 1 for negative, 0 for zero and 2 for positive.
- R9: Signed multiply.
  - Selector 25 takes the 64-bit product in `dst_i`. It gives 0 for zero, and 3 unless bits 63..31 are all equal. Otherwise it gives 1 if bit 63 is set and 2 if it is clear.
  - Selector 26 takes the high half in `src_i` and the low half in `dst_i`. It gives 0 when both are zero, and 3 unless the high half is the sign extension of the low half's bit 63. Otherwise it gives 1 if the high half is negative and 2 if it is not.
- R10: Selector 27 is an arithmetic left shift of `src_i` by n=`dst_i[5:0]`.
  - The code is 3 when the top n+1 source bits are not all equal to bit 63.
  - Otherwise the shifted word takes the original bit 63 with the shifted low bits. The code is 0 if that word is zero, 1 if it is negative and 2 if it is positive.
- R11: Three selectors test a single value or a match mask.
  - Selector 28 gives 2 for nonzero `dst_i` and 0 for zero.
  - Selector 29 gives 0 when `dst_i` equals 16 and 3 otherwise.
  - Selector 30 treats {`dst_i`,`src_i`} as a 128-bit match mask. It gives 0 when all bits are ones, 3 when all are zeros, and 1 otherwise.
- R12: Selector 31 is undefined. Accepting it sets `err_o`=1 and leaves `cc_o` unchanged. The next accepted defined selector clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle; always accepted |
| op_i | input | 5 | Operation class selector |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Destination or result operand |
| xres_i | input | 64 | Extra result word for signed add/subtract |
| out_valid | output | 1 | A new code is present this cycle |
| cc_o | output | 2 | Registered condition code |
| err_o | output | 1 | Last accepted selector was undefined |

## Verification
The bench builds the block with its default 64-bit data width, which gives a 32-bit half width and a block-count target of 16. These values exercise the sign bits of both halves, the most negative value at each width and the full shift-count range up to 63. They also exercise the multiply range check across bit 31 and the 128-bit all/none match mask. Each operation class is covered by directed cases, including the boundaries:
- overflow and its absence;
- an empty mask;
- the borrow fold;
- the undefined selector.

// File: rtl/cond_code_pkg.sv
package cond_code_pkg;

  typedef enum logic [4:0] {
    OP_K0      = 5'd0,
    OP_K1      = 5'd1,
    OP_K2      = 5'd2,
    OP_K3      = 5'd3,
    OP_ZCMP_W  = 5'd4,
    OP_ZCMP_D  = 5'd5,
    OP_SCMP_W  = 5'd6,
    OP_SCMP_D  = 5'd7,
    OP_UCMP_W  = 5'd8,
    OP_UCMP_D  = 5'd9,
    OP_TST_W   = 5'd10,
    OP_TST_D   = 5'd11,
    OP_INS     = 5'd12,
    OP_SADD_W  = 5'd13,
    OP_SADD_D  = 5'd14,
    OP_SSUB_W  = 5'd15,
    OP_SSUB_D  = 5'd16,
    OP_LADD    = 5'd17,
    OP_LSUB    = 5'd18,
    OP_ABS_W   = 5'd19,
    OP_ABS_D   = 5'd20,
    OP_NABS_W  = 5'd21,
    OP_NABS_D  = 5'd22,
    OP_CPL_W   = 5'd23,
    OP_CPL_D   = 5'd24,
    OP_SMUL_W  = 5'd25,
    OP_SMUL_D  = 5'd26,
    OP_SHL     = 5'd27,
    OP_LONE    = 5'd28,
    OP_BCNT    = 5'd29,
    OP_VMATCH  = 5'd30
  } cc_op_e;

  // negative -> 1, zero -> 0, positive -> 2
  function automatic logic [1:0] sign_code(input logic neg, input logic zero);
    return neg ? 2'd1 : (zero ? 2'd0 : 2'd2);
  endfunction

  // equal -> 0, less -> 1, greater -> 2
  function automatic logic [1:0] order_code(input logic eq, input logic lt);
    return eq ? 2'd0 : (lt ? 2'd1 : 2'd2);
  endfunction

endpackage

// File: rtl/cc_msb_pick.sv
// Priority encoder on the mask: returns the value bit at the highest set mask bit.
module cc_msb_pick #(
  parameter int W = 64
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  output logic         bit_at
);
  always_comb begin
    bit_at = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (mask[i]) bit_at = value[i];
    end
  end
endmodule

// File: rtl/cc_arith_flags.sv
// Ordering, overflow and classification flags for one operand width.
module cc_arith_flags #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] r,
  output logic         eq,
  output logic         lt_s,
  output logic         lt_u,
  output logic         add_ovf,
  output logic         sub_ovf,
  output logic         r_neg,
  output logic         r_zero,
  output logic         b_neg,
  output logic         b_zero,
  output logic         b_minneg
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic a_neg, a_pos, b_pos, r_pos;

  always_comb begin
    a_neg    = a[W-1];
    a_pos    = ~a[W-1] & (|a);
    b_neg    = b[W-1];
    b_pos    = ~b[W-1] & (|b);
    r_neg    = r[W-1];
    r_pos    = ~r[W-1] & (|r);
    r_zero   = ~(|r);
    b_zero   = ~(|b);
    b_minneg = (b == MIN_NEG);
    eq       = (a == b);
    lt_s     = ($signed(a) < $signed(b));
    lt_u     = (a < b);
    add_ovf  = (a_pos & b_pos & r_neg) | (a_neg & b_neg & ~r_neg);
    sub_ovf  = (~a_neg & b_neg & r_neg) | (a_neg & b_pos & r_pos);
  end
endmodule

// File: rtl/cc_shift_ovf.sv
// Arithmetic left shift: overflow detection and sign/zero class of the shifted word.
module cc_shift_ovf #(
  parameter  int W  = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  output logic [1:0]    code
);
  logic [SW-1:0] keep;
  logic [W-1:0]  top_mask, match, shifted, res;

  always_comb begin
    keep     = SW'(W - 1) - amt;
    top_mask = {W{1'b1}} << keep;
    match    = val[W-1] ? top_mask : '0;
    shifted  = val << amt;
    res      = {val[W-1], shifted[W-2:0]};
    if ((val & top_mask) != match) code = 2'd3;
    else if (res == '0)            code = 2'd0;
    else if (res[W-1])             code = 2'd1;
    else                           code = 2'd2;
  end
endmodule

// File: rtl/cond_code_gen.sv
module cond_code_gen #(
  parameter int DATA_W    = 64,
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [4:0]  op_i,
  input  logic [63:0] src_i,
  input  logic [63:0] dst_i,
  input  logic [63:0] xres_i,
  output logic        out_valid,
  output logic [1:0]  cc_o,
  output logic        err_o
);
  import cond_code_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  // index 0: half width, index 1: full width
  logic [1:0] f_eq, f_lts, f_ltu, f_aovf, f_sovf, f_rneg, f_rzero, f_bneg, f_bzero, f_bmin;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W = (g == 0) ? HALF_W : DATA_W;
    cc_arith_flags #(.W(W)) u_flags (
      .a       (src_i[W-1:0]),
      .b       (dst_i[W-1:0]),
      .r       (xres_i[W-1:0]),
      .eq      (f_eq[g]),
      .lt_s    (f_lts[g]),
      .lt_u    (f_ltu[g]),
      .add_ovf (f_aovf[g]),
      .sub_ovf (f_sovf[g]),
      .r_neg   (f_rneg[g]),
      .r_zero  (f_rzero[g]),
      .b_neg   (f_bneg[g]),
      .b_zero  (f_bzero[g]),
      .b_minneg(f_bmin[g])
    );
  end

  logic tst_bit, ins_bit;
  cc_msb_pick #(.W(DATA_W)) u_pick_tst (.mask(dst_i), .value(src_i), .bit_at(tst_bit));
  cc_msb_pick #(.W(DATA_W)) u_pick_ins (.mask(src_i), .value(dst_i), .bit_at(ins_bit));

  logic [1:0] shl_code;
  cc_shift_ovf #(.W(DATA_W)) u_shl (.val(src_i), .amt(dst_i[SH_W-1:0]), .code(shl_code));

  logic [HALF_W-1:0] tm_w;
  logic [DATA_W-1:0] tm_d;
  logic [HALF_W:0]   mul_hi;
  logic [1:0]        nxt_cc;
  logic              bad_op;

  always_comb begin
    tm_w   = src_i[HALF_W-1:0] & dst_i[HALF_W-1:0];
    tm_d   = src_i & dst_i;
    mul_hi = dst_i[DATA_W-1:HALF_W-1];
    nxt_cc = cc_o;
    bad_op = 1'b0;
    case (op_i)
      OP_K0, OP_K1, OP_K2, OP_K3: nxt_cc = op_i[1:0];
      OP_ZCMP_W: nxt_cc = sign_code(f_bneg[0], f_bzero[0]);
      OP_ZCMP_D: nxt_cc = sign_code(f_bneg[1], f_bzero[1]);
      OP_SCMP_W: nxt_cc = order_code(f_eq[0], f_lts[0]);
      OP_SCMP_D: nxt_cc = order_code(f_eq[1], f_lts[1]);
      OP_UCMP_W: nxt_cc = order_code(f_eq[0], f_ltu[0]);
      OP_UCMP_D: nxt_cc = order_code(f_eq[1], f_ltu[1]);
      OP_TST_W:
        if (tm_w == '0)                     nxt_cc = 2'd0;
        else if (tm_w == dst_i[HALF_W-1:0]) nxt_cc = 2'd3;
        else                                nxt_cc = 2'd1;
      OP_TST_D:
        if (tm_d == '0)         nxt_cc = 2'd0;
        else if (tm_d == dst_i) nxt_cc = 2'd3;
        else                    nxt_cc = tst_bit ? 2'd2 : 2'd1;
      OP_INS:
        if (tm_d == '0) nxt_cc = 2'd0;
        else            nxt_cc = ins_bit ? 2'd1 : 2'd2;
      OP_SADD_W: nxt_cc = f_aovf[0] ? 2'd3 : sign_code(f_rneg[0], f_rzero[0]);
      OP_SADD_D: nxt_cc = f_aovf[1] ? 2'd3 : sign_code(f_rneg[1], f_rzero[1]);
      OP_SSUB_W: nxt_cc = f_sovf[0] ? 2'd3 : sign_code(f_rneg[0], f_rzero[0]);
      OP_SSUB_D: nxt_cc = f_sovf[1] ? 2'd3 : sign_code(f_rneg[1], f_rzero[1]);
      OP_LADD:   nxt_cc = {src_i[0], |dst_i};
      OP_LSUB:   nxt_cc = {~src_i[0], |dst_i};   // borrow flag set folds 2*2 out of 2 bits
      OP_ABS_W:  nxt_cc = f_bmin[0] ? 2'd3 : (f_bzero[0] ? 2'd0 : 2'd2);
      OP_ABS_D:  nxt_cc = f_bmin[1] ? 2'd3 : (f_bzero[1] ? 2'd0 : 2'd2);
      OP_NABS_W: nxt_cc = {1'b0, ~f_bzero[0]};
      OP_NABS_D: nxt_cc = {1'b0, ~f_bzero[1]};
      OP_CPL_W:  nxt_cc = f_bmin[0] ? 2'd3 : sign_code(f_bneg[0], f_bzero[0]);
      OP_CPL_D:  nxt_cc = f_bmin[1] ? 2'd3 : sign_code(f_bneg[1], f_bzero[1]);
      OP_SMUL_W:
        if (dst_i == '0)                     nxt_cc = 2'd0;
        else if (!((&mul_hi) || ~(|mul_hi))) nxt_cc = 2'd3;
        else                                 nxt_cc = dst_i[DATA_W-1] ? 2'd1 : 2'd2;
      OP_SMUL_D:
        if (src_i == '0 && dst_i == '0)              nxt_cc = 2'd0;
        else if (src_i != {DATA_W{dst_i[DATA_W-1]}}) nxt_cc = 2'd3;
        else                                         nxt_cc = src_i[DATA_W-1] ? 2'd1 : 2'd2;
      OP_SHL:    nxt_cc = shl_code;
      OP_LONE:   nxt_cc = (|dst_i) ? 2'd2 : 2'd0;
      OP_BCNT:   nxt_cc = (dst_i == 64'(BLK_BYTES)) ? 2'd0 : 2'd3;
      OP_VMATCH:
        if ((&src_i) && (&dst_i))          nxt_cc = 2'd0;
        else if (~(|src_i) && ~(|dst_i))   nxt_cc = 2'd3;
        else                               nxt_cc = 2'd1;
      default: bad_op = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cc_o      <= 2'd0;
      err_o     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        err_o <= bad_op;
        cc_o  <= nxt_cc;
      end
    end
  end
endmodule

// File: rtl/cond_code_gen_chk.sv
module cond_code_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  op_i,
  input logic [63:0] src_i,
  input logic [63:0] dst_i,
  input logic        out_valid,
  input logic [1:0]  cc_o,
  input logic        err_o
);
  // R1: one-cycle latency of the valid strobe
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: idle cycle holds the code
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cc_o) && $stable(err_o)));

  // R2: constant selectors
  a_r2_const: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i < 5'd4) |=> (cc_o == $past(op_i[1:0]) && !err_o));

  // R8: most negative 64-bit value under absolute value
  a_r8_abs_minneg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 5'd20 && dst_i == 64'h8000_0000_0000_0000) |=> cc_o == 2'd3);

  // R11: all-ones match mask
  a_r11_all_match: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 5'd30 && (&src_i) && (&dst_i)) |=> cc_o == 2'd0);

  // R12: undefined selector flags error, keeps code
  a_r12_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 5'd31) |=> (err_o && cc_o == $past(cc_o)));
endmodule

bind cond_code_gen cond_code_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op_i     (op_i),
  .src_i    (src_i),
  .dst_i    (dst_i),
  .out_valid(out_valid),
  .cc_o     (cc_o),
  .err_o    (err_o)
);

// File: tb/cond_code_gen_tb.sv
module cond_code_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] src_i = '0, dst_i = '0, xres_i = '0;
  logic        out_valid, err_o;
  logic [1:0]  cc_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MN64 = 64'h8000_0000_0000_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_code_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .xres_i(xres_i),
    .out_valid(out_valid), .cc_o(cc_o), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [1:0] exp_cc, input logic exp_err,
                       input logic exp_ov);
    n_checks++;
    if (cc_o !== exp_cc || err_o !== exp_err || out_valid !== exp_ov) begin
      n_fails++;
      $display("FAIL %s: cc=%0d err=%0b ov=%0b expected cc=%0d err=%0b ov=%0b",
               tag, cc_o, err_o, out_valid, exp_cc, exp_err, exp_ov);
    end
  endtask

  task automatic run_op(input logic [4:0] o, input logic [63:0] s, input logic [63:0] d,
                        input logic [63:0] x, input logic [1:0] exp_cc, input string tag);
    @(negedge clk);
    op_i = o; src_i = s; dst_i = d; xres_i = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, exp_cc, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    check("R1 reset", 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_timing;
    run_op(5'd2, 0, 0, 0, 2'd2, "R1 capture");
    @(negedge clk);
    op_i = 5'd1; src_i = ALL1; dst_i = ALL1;   // no valid: must not change
    @(negedge clk);
    check("R1 idle hold", 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_const;
    run_op(5'd1, ALL1, ALL1, 0, 2'd1, "R2 const1");
    run_op(5'd3, 0, 0, 0, 2'd3, "R2 const3");
    run_op(5'd0, ALL1, 0, 0, 2'd0, "R2 const0");
  endtask

  task automatic t_compare;
    run_op(5'd6, 64'hFFFF_FFFF, 64'd1, 0, 2'd1, "R3 signed32 lt");
    run_op(5'd8, 64'hFFFF_FFFF, 64'd1, 0, 2'd2, "R3 unsigned32 gt");
    run_op(5'd9, 64'h1234, 64'h1234, 0, 2'd0, "R3 unsigned64 eq");
    run_op(5'd7, 64'd5, -64'sd3, 0, 2'd2, "R3 signed64 gt");
    run_op(5'd4, 0, 64'h8000_0000, 0, 2'd1, "R3 zero32 neg");
    run_op(5'd5, 0, 64'h8000_0000, 0, 2'd2, "R3 zero64 pos");
  endtask

  task automatic t_test_mask;
    run_op(5'd10, 64'hF0, 64'hF0, 0, 2'd3, "R4 tm32 all");
    run_op(5'd10, 64'h80, 64'hF0, 0, 2'd1, "R4 tm32 mixed");
    run_op(5'd11, 64'h80, 64'hF0, 0, 2'd2, "R4 tm64 mixed top set");
    run_op(5'd11, 64'h10, 64'hF0, 0, 2'd1, "R4 tm64 mixed top clear");
    run_op(5'd11, ALL1, 64'h0, 0, 2'd0, "R4 tm64 empty mask");
  endtask

  task automatic t_insert;
    run_op(5'd12, 64'hFF00, 64'h8000, 0, 2'd1, "R5 ins top one");
    run_op(5'd12, 64'hFF00, 64'h0100, 0, 2'd2, "R5 ins top zero");
    run_op(5'd12, 64'hFF00, 64'h00FF, 0, 2'd0, "R5 ins none");
  endtask

  task automatic t_signed_arith;
    run_op(5'd13, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3, "R6 add32 ovf");
    run_op(5'd14, 64'd5, -64'sd7, -64'sd2, 2'd1, "R6 add64 neg");
    run_op(5'd16, MN64, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 2'd3, "R6 sub64 ovf");
    run_op(5'd15, 64'd3, 64'd3, 64'd0, 2'd0, "R6 sub32 zero");
    run_op(5'd16, 64'd9, 64'd4, 64'd5, 2'd2, "R6 sub64 pos");
  endtask

  task automatic t_logical;
    run_op(5'd17, 64'd1, 64'd0, 0, 2'd2, "R7 addu carry zero");
    run_op(5'd17, 64'd0, 64'd5, 0, 2'd1, "R7 addu nz");
    run_op(5'd18, 64'd0, 64'd5, 0, 2'd3, "R7 subu flag0 nz");
    run_op(5'd18, 64'd1, 64'd0, 0, 2'd0, "R7 subu flag1 fold");
  endtask

  task automatic t_unary;
    run_op(5'd20, 0, MN64, 0, 2'd3, "R8 abs64 minneg");
    run_op(5'd19, 0, 64'hFFFF_FFFF_0000_0000, 0, 2'd0, "R8 abs32 zero low");
    run_op(5'd19, 0, 64'h8000_0000, 0, 2'd3, "R8 abs32 minneg");
    run_op(5'd22, 0, 64'd4, 0, 2'd1, "R8 nabs64 nz");
    run_op(5'd21, 0, 64'h1_0000_0000, 0, 2'd0, "R8 nabs32 zero low");
    run_op(5'd24, 0, ALL1, 0, 2'd1, "R8 comp64 neg");
    run_op(5'd23, 0, 64'd7, 0, 2'd2, "R8 comp32 pos");
  endtask

  task automatic t_multiply;
    run_op(5'd25, 0, 64'h8000_0000, 0, 2'd3, "R9 mul32 ovf");
    run_op(5'd25, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 2'd1, "R9 mul32 neg");
    run_op(5'd26, 64'd0, MN64, 0, 2'd3, "R9 mul64 ovf");
    run_op(5'd26, ALL1, ALL1, 0, 2'd1, "R9 mul64 neg");
    run_op(5'd26, 64'd0, 64'd0, 0, 2'd0, "R9 mul64 zero");
    run_op(5'd26, 64'd0, 64'd5, 0, 2'd2, "R9 mul64 pos");
  endtask

  task automatic t_shift;
    run_op(5'd27, 64'h4000_0000_0000_0000, 64'd1, 0, 2'd3, "R10 sla ovf");
    run_op(5'd27, 64'd1, 64'd3, 0, 2'd2, "R10 sla pos");
    run_op(5'd27, ALL1, 64'd4, 0, 2'd1, "R10 sla neg");
    run_op(5'd27, 64'd0, 64'd63, 0, 2'd0, "R10 sla zero max count");
    run_op(5'd27, 64'hC000_0000_0000_0000, 64'd1, 0, 2'd1, "R10 sla sign kept");
  endtask

  task automatic t_misc;
    run_op(5'd28, 0, 64'd0, 0, 2'd0, "R11 lone zero");
    run_op(5'd28, 0, 64'd9, 0, 2'd2, "R11 lone nz");
    run_op(5'd29, 0, 64'd16, 0, 2'd0, "R11 bcnt full");
    run_op(5'd29, 0, 64'd15, 0, 2'd3, "R11 bcnt short");
    run_op(5'd30, ALL1, ALL1, 0, 2'd0, "R11 vmatch all");
    run_op(5'd30, 0, 0, 0, 2'd3, "R11 vmatch none");
    run_op(5'd30, 64'd1, 0, 0, 2'd1, "R11 vmatch some");
  endtask

  task automatic t_bad_op;
    run_op(5'd2, 0, 0, 0, 2'd2, "R12 prime");
    @(negedge clk);
    op_i = 5'd31; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 undefined flags error", 2'd2, 1'b1, 1'b1);
    run_op(5'd1, 0, 0, 0, 2'd1, "R12 error cleared");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_timing();
    t_const();
    t_compare();
    t_test_mask();
    t_insert();
    t_signed_arith();
    t_logical();
    t_unary();
    t_multiply();
    t_shift();
    t_misc();
    t_bad_op();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end
endmodule